// File: doc/BRIEF.md
# 1-Wire ROM Search Sequencer

This block runs the binary-tree enumeration of device identifiers on a 1-Wire bus. It does not touch the bus wire. It drives a separate timeslot engine through a request/done handshake and asks it for three kinds of slot: a bus reset with presence detect, a single-bit write, and a single-bit read. Each pulse on `startReq` runs one complete pass, which finds one device. The block keeps its discrepancy bookkeeping from one pass to the next, so repeated start requests walk through every device on the bus in turn. After the last device it reports not-found once and then starts the enumeration again from the beginning.

A pass has four steps. It resets the bus and sends the search command byte. It then handles each of the 64 identifier bits by reading the bit, reading its complement, picking a branch and writing that branch back to the bus. At the end it checks the assembled identifier with the 8-bit 1-Wire CRC. The CRC is computed serially as each branch bit is chosen, so the check takes no extra pass over the identifier. The result appears on the ports with a one-cycle completion pulse: a found flag, the 64-bit identifier, a last-device flag and the most recent family-level branch index. A separate clear input forgets all enumeration state.

Top module: `owsrch_top`

## Requirements
- R1: Every pass starts with a reset slot (`slotOp` = 0). If the reset response is 0 (no presence) or the last-device flag is already set, the pass ends not-found and the search state is cleared.
- R2: After a reset with presence, the command byte 0xF0 is sent as eight write slots (`slotOp` = 1, bit on `slotBit`), least-significant bit first.
- R3: For each identifier index 1 to 64, the block issues a read slot (`slotOp` = 2) for the identifier bit, then a read slot for its complement, then one write slot. If both reads return 1, the pass ends not-found at once and the search state is cleared.
- R4: When the two read bits differ, the branch written is the identifier bit, which is the first read.
- R5: When both read bits are 0, the branch depends on the index. It is 1 at an index equal to the stored last-discrepancy index, 0 above that index, and the stored identifier bit at that index below it.
- R6: A conflict (both reads 0) that resolves to 0 records its index as the pass's last zero. If the index is 8 or less, it also becomes the value on `familyDisc`, which holds its value across passes until the state is cleared.
- R7: The chosen branch for index n is stored in `romId[n-1]`, so index 1 is the LSB of byte 0. The same value is sent in that index's write slot.
- R8: After index 64, the last-discrepancy index takes the pass's last-zero value. If that value is 0, `lastDevice` becomes 1.
- R9: The CRC-8 (reflected polynomial 0x8C, initial 0, LSB first) of the 64 assembled bits must be 0. A nonzero residue ends the pass not-found and clears the search state.
- R10: Clearing the search state sets `romId`, `familyDisc`, `lastDevice` and the last-discrepancy index to 0. `clearReq` clears the state when the block is idle. `clearReq` and `startReq` have no effect while `busy` is 1.
- R11: After reset, `found`, `lastDevice`, `romId`, `busy`, `slotReq` and `doneStrobe` are 0. `slotReq` is a one-cycle pulse, and the block issues no new request until `slotDone`. `doneStrobe` is a one-cycle pulse, and `found` is valid from that cycle until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start one search pass (honoured when idle) |
| clearReq | input | 1 | Clear the search state (honoured when idle) |
| slotReq | output | 1 | One-cycle request to the timeslot engine |
| slotOp | output | 2 | Slot kind: 0 reset, 1 write bit, 2 read bit |
| slotBit | output | 1 | Bit value for a write slot |
| slotDone | input | 1 | Engine pulse: requested slot finished |
| slotRsp | input | 1 | Slot result: presence for reset, sampled bit for read |
| busy | output | 1 | A pass is in progress |
| doneStrobe | output | 1 | One-cycle pulse at the end of a pass |
| found | output | 1 | Last pass found a device with a valid CRC |
| romId | output | 64 | Current identifier (bit n-1 is index n) |
| lastDevice | output | 1 | Enumeration has reached its final device |
| familyDisc | output | 4 | Latest conflict index of 8 or less that resolved to 0 |

## Verification
A wrong last-discrepancy index or wrong stored identifier bits do not show up at once. They first appear on the next pass, as a device found twice, a device skipped, or `lastDevice` set one pass too early or too late. The bench therefore runs whole enumerations and compares every pass against the order the requirements imply: ascending by identifier read LSB first. A wrong serial CRC state shows only at the end of a pass, as a false not-found. A stale family index shows on `familyDisc` in the completion cycle of the pass that should have updated it.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } slotOpE;

  // Strobes from the sequencer into the datapath, one cycle each
  typedef struct packed {
    logic startRun;   // begin a pass: index, last zero, crc, command counter
    logic clrState;   // forget enumeration state
    logic cmdAdvance; // next command bit
    logic takeId;     // capture identifier bit read
    logic takeCmp;    // capture complement bit read
    logic commit;     // store branch, update crc and discrepancy tracking
    logic finish;     // fold last zero into last discrepancy
  } strobeS;

endpackage

// File: rtl/owsrch_dpath.sv
module owsrch_dpath
  import owsrch_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int FAM_LIMIT = 8,
  parameter int CMD_BITS = 8,
  parameter logic [CMD_BITS-1:0] CMD_CODE = 8'hF0,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h8C,
  localparam int IDX_W = $clog2(ID_BITS + 2),
  localparam int POS_W = $clog2(ID_BITS),
  localparam int FAM_W = $clog2(FAM_LIMIT + 1),
  localparam int CNT_W = (CMD_BITS > 1) ? $clog2(CMD_BITS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeS             strb,
  input  logic               slotRsp,
  output logic               dirBit,
  output logic               bothOnes,
  output logic               cmdBit,
  output logic               cmdLast,
  output logic               scanDone,
  output logic               crcOk,
  output logic [ID_BITS-1:0] romId,
  output logic               lastDevice,
  output logic [FAM_W-1:0]   familyDisc
);

  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(ID_BITS + 1);
  localparam logic [IDX_W-1:0] FAM_TOP   = IDX_W'(FAM_LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CMD_BITS - 1);

  logic [ID_BITS-1:0] romReg;
  logic [IDX_W-1:0]   bitIdx;
  logic [IDX_W-1:0]   lastDisc;
  logic [IDX_W-1:0]   lastZero;
  logic [FAM_W-1:0]   famReg;
  logic               lastDevReg;
  logic [CRC_W-1:0]   crcReg;
  logic               idBit;
  logic               cmpBit;
  logic [CNT_W-1:0]   cmdCnt;

  logic [POS_W-1:0]   pos;
  logic               conflict;
  logic [CRC_W-1:0]   crcNext;

  assign pos      = POS_W'(bitIdx - IDX_FIRST);
  assign conflict = !idBit && !cmpBit;
  assign bothOnes = idBit && cmpBit;

  // Branch choice
  always_comb begin
    if (!conflict) begin
      dirBit = idBit;
    end else if (bitIdx == lastDisc) begin
      dirBit = 1'b1;
    end else if (bitIdx > lastDisc) begin
      dirBit = 1'b0;
    end else begin
      dirBit = romReg[pos];
    end
  end

  // Serial reflected CRC step on the chosen branch bit
  always_comb begin
    logic fb;
    fb = crcReg[0] ^ dirBit;
    crcNext = {1'b0, crcReg[CRC_W-1:1]} ^ (fb ? CRC_POLY : '0);
  end

  assign cmdBit   = CMD_CODE[cmdCnt];
  assign cmdLast  = (cmdCnt == CNT_LAST);
  assign scanDone = (bitIdx == IDX_END);
  assign crcOk    = (crcReg == '0);

  // Per-pass working registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= IDX_FIRST;
      lastZero <= '0;
      crcReg   <= '0;
      cmdCnt   <= '0;
      idBit    <= 1'b0;
      cmpBit   <= 1'b0;
    end else begin
      if (strb.startRun) begin
        bitIdx   <= IDX_FIRST;
        lastZero <= '0;
        crcReg   <= '0;
        cmdCnt   <= '0;
      end
      if (strb.cmdAdvance) cmdCnt <= cmdCnt + CNT_W'(1);
      if (strb.takeId)     idBit  <= slotRsp;
      if (strb.takeCmp)    cmpBit <= slotRsp;
      if (strb.commit) begin
        crcReg <= crcNext;
        bitIdx <= bitIdx + IDX_FIRST;
        if (conflict && !dirBit) lastZero <= bitIdx;
      end
    end
  end

  // Enumeration state kept across passes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      romReg     <= '0;
      lastDisc   <= '0;
      famReg     <= '0;
      lastDevReg <= 1'b0;
    end else if (strb.clrState) begin
      romReg     <= '0;
      lastDisc   <= '0;
      famReg     <= '0;
      lastDevReg <= 1'b0;
    end else begin
      if (strb.commit) begin
        romReg[pos] <= dirBit;
        if (conflict && !dirBit && (bitIdx <= FAM_TOP)) famReg <= FAM_W'(bitIdx);
      end
      if (strb.finish) begin
        lastDisc   <= lastZero;
        lastDevReg <= (lastZero == '0);
      end
    end
  end

  assign romId      = romReg;
  assign lastDevice = lastDevReg;
  assign familyDisc = famReg;

  // R10: a clear leaves every piece of enumeration state at zero
  p_clear_zeroes_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrState |=> (romReg == '0 && lastDisc == '0 && famReg == '0 && !lastDevReg));

  // R6: family index never exceeds the family limit
  p_fam_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    famReg <= FAM_W'(FAM_LIMIT));

  // R3: index stays within 1..ID_BITS+1
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx >= IDX_FIRST) && (bitIdx <= IDX_END));

  // R8: the last-device flag rises only with an empty last discrepancy
  p_lastdev_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lastDevReg) |-> (lastDisc == '0));

  // R7: a committed branch lands at its index
  p_commit_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.clrState) |=> (romReg[$past(pos)] == $past(dirBit)));

endmodule

// File: rtl/owsrch_ctrl.sv
module owsrch_ctrl
  import owsrch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   clearReq,
  input  logic   slotDone,
  input  logic   slotRsp,
  input  logic   dirBit,
  input  logic   bothOnes,
  input  logic   cmdBit,
  input  logic   cmdLast,
  input  logic   scanDone,
  input  logic   crcOk,
  input  logic   lastDevice,
  output strobeS strb,
  output logic   slotReq,
  output slotOpE slotOp,
  output logic   slotBit,
  output logic   busy,
  output logic   doneStrobe,
  output logic   found
);

  typedef enum logic [3:0] {
    C_IDLE, C_RST_REQ, C_RST_WAIT, C_CMD_REQ, C_CMD_WAIT,
    C_RDA_REQ, C_RDA_WAIT, C_RDB_REQ, C_RDB_WAIT,
    C_CHOOSE, C_WR_REQ, C_WR_WAIT, C_CHECK
  } ctlStateE;

  ctlStateE state, nxt;
  logic     endOk, endFail;

  always_comb begin
    nxt     = state;
    strb    = '0;
    slotReq = 1'b0;
    slotOp  = OP_READ;
    slotBit = 1'b1;
    endOk   = 1'b0;
    endFail = 1'b0;
    unique case (state)
      C_IDLE: begin
        if (startReq) begin
          strb.startRun = 1'b1;
          nxt = C_RST_REQ;
        end else if (clearReq) begin
          strb.clrState = 1'b1;
        end
      end
      C_RST_REQ: begin
        slotReq = 1'b1;
        slotOp  = OP_RESET;
        nxt     = C_RST_WAIT;
      end
      C_RST_WAIT: begin
        if (slotDone) begin
          if (!slotRsp || lastDevice) begin
            strb.clrState = 1'b1;
            endFail = 1'b1;
            nxt = C_IDLE;
          end else begin
            nxt = C_CMD_REQ;
          end
        end
      end
      C_CMD_REQ: begin
        slotReq = 1'b1;
        slotOp  = OP_WRITE;
        slotBit = cmdBit;
        nxt     = C_CMD_WAIT;
      end
      C_CMD_WAIT: begin
        if (slotDone) begin
          if (cmdLast) begin
            nxt = C_RDA_REQ;
          end else begin
            strb.cmdAdvance = 1'b1;
            nxt = C_CMD_REQ;
          end
        end
      end
      C_RDA_REQ: begin
        slotReq = 1'b1;
        nxt     = C_RDA_WAIT;
      end
      C_RDA_WAIT: begin
        if (slotDone) begin
          strb.takeId = 1'b1;
          nxt = C_RDB_REQ;
        end
      end
      C_RDB_REQ: begin
        slotReq = 1'b1;
        nxt     = C_RDB_WAIT;
      end
      C_RDB_WAIT: begin
        if (slotDone) begin
          strb.takeCmp = 1'b1;
          nxt = C_CHOOSE;
        end
      end
      C_CHOOSE: begin
        if (bothOnes) begin
          strb.clrState = 1'b1;
          endFail = 1'b1;
          nxt = C_IDLE;
        end else begin
          nxt = C_WR_REQ;
        end
      end
      C_WR_REQ: begin
        slotReq     = 1'b1;
        slotOp      = OP_WRITE;
        slotBit     = dirBit;
        strb.commit = 1'b1;
        nxt         = C_WR_WAIT;
      end
      C_WR_WAIT: begin
        if (slotDone) nxt = scanDone ? C_CHECK : C_RDA_REQ;
      end
      C_CHECK: begin
        if (crcOk) begin
          strb.finish = 1'b1;
          endOk = 1'b1;
        end else begin
          strb.clrState = 1'b1;
          endFail = 1'b1;
        end
        nxt = C_IDLE;
      end
      default: nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= C_IDLE;
      doneStrobe <= 1'b0;
      found      <= 1'b0;
    end else begin
      state      <= nxt;
      doneStrobe <= endOk || endFail;
      if (endOk)        found <= 1'b1;
      else if (endFail) found <= 1'b0;
    end
  end

  assign busy = (state != C_IDLE);

  // R11: requests are single-cycle pulses
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |=> !slotReq);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R9: a reported find always carries a zero CRC residue
  p_found_crc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && found) |-> crcOk);

  // R11: no request goes out while a pass is idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !slotReq);

endmodule

// File: rtl/owsrch_top.sv
module owsrch_top
  import owsrch_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int FAM_LIMIT = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             startReq,
  input  logic                             clearReq,
  output logic                             slotReq,
  output logic [1:0]                       slotOp,
  output logic                             slotBit,
  input  logic                             slotDone,
  input  logic                             slotRsp,
  output logic                             busy,
  output logic                             doneStrobe,
  output logic                             found,
  output logic [ID_BITS-1:0]               romId,
  output logic                             lastDevice,
  output logic [$clog2(FAM_LIMIT+1)-1:0]   familyDisc
);

  strobeS strb;
  slotOpE opInt;
  logic   dirBit, bothOnes, cmdBit, cmdLast, scanDone, crcOk;

  owsrch_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .clearReq   (clearReq),
    .slotDone   (slotDone),
    .slotRsp    (slotRsp),
    .dirBit     (dirBit),
    .bothOnes   (bothOnes),
    .cmdBit     (cmdBit),
    .cmdLast    (cmdLast),
    .scanDone   (scanDone),
    .crcOk      (crcOk),
    .lastDevice (lastDevice),
    .strb       (strb),
    .slotReq    (slotReq),
    .slotOp     (opInt),
    .slotBit    (slotBit),
    .busy       (busy),
    .doneStrobe (doneStrobe),
    .found      (found)
  );

  owsrch_dpath #(
    .ID_BITS   (ID_BITS),
    .FAM_LIMIT (FAM_LIMIT)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .slotRsp    (slotRsp),
    .dirBit     (dirBit),
    .bothOnes   (bothOnes),
    .cmdBit     (cmdBit),
    .cmdLast    (cmdLast),
    .scanDone   (scanDone),
    .crcOk      (crcOk),
    .romId      (romId),
    .lastDevice (lastDevice),
    .familyDisc (familyDisc)
  );

  assign slotOp = opInt;

endmodule

// File: tb/owsrch_top_tb_top.sv
`timescale 1ns/1ps
module owsrch_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        clearReq = 1'b0;
  logic        slotDone = 1'b0;
  logic        slotRsp = 1'b0;
  logic        slotReq, slotBit, busy, doneStrobe, found, lastDevice;
  logic [1:0]  slotOp;
  logic [63:0] romId;
  logic [3:0]  familyDisc;

  always #10 clk = ~clk;

  owsrch_top dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clearReq(clearReq),
    .slotReq(slotReq), .slotOp(slotOp), .slotBit(slotBit),
    .slotDone(slotDone), .slotRsp(slotRsp), .busy(busy),
    .doneStrobe(doneStrobe), .found(found), .romId(romId),
    .lastDevice(lastDevice), .familyDisc(familyDisc)
  );

  int checks = 0;
  int fails = 0;

  typedef struct {
    bit          fnd;
    logic [63:0] rom;
    bit          last;
    logic [3:0]  fam;
    string       tag;
  } expT;
  expT expQ[$];

  // Bus device model
  logic [63:0] devRom [8];
  int          nDev = 0;
  int          vanishAt = 0;
  bit          devIn [8];
  int          phase = 0;
  int          cmdBits = 0;
  logic [7:0]  cmdShift = '0;
  int          sIdx = 1;
  int          sSub = 0;

  // Expected enumeration model
  int order [8];
  int expK = 0;
  bit expLast = 0;
  int expFam = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(logic [55:0] data);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ data[i];
      c = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [63:0] mkRom(logic [7:0] fam, logic [47:0] ser);
    logic [55:0] body = {ser, fam};
    return {crc8(body), body};
  endfunction

  function automatic logic [63:0] rev64(logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[63-i];
    return r;
  endfunction

  function automatic int famFor(int d);
    int r = 0;
    for (int i = 1; i <= 8; i++) begin
      logic [63:0] m = (64'd1 << (i - 1)) - 64'd1;
      if (devRom[d][i-1] == 1'b0)
        for (int e = 0; e < nDev; e++)
          if (e != d && ((devRom[e] ^ devRom[d]) & m) == 64'd0 && devRom[e][i-1] != devRom[d][i-1])
            r = i;
    end
    return r;
  endfunction

  task automatic sortDevices();
    for (int i = 0; i < nDev; i++) order[i] = i;
    for (int i = 0; i < nDev; i++)
      for (int j = i + 1; j < nDev; j++)
        if (rev64(devRom[order[j]]) < rev64(devRom[order[i]])) begin
          int t = order[i];
          order[i] = order[j];
          order[j] = t;
        end
  endtask

  // Slot responder: a set of devices sharing the bus
  task automatic serve(input logic [1:0] op, input logic b, output logic r);
    r = 1'b1;
    case (op)
      2'd0: begin
        phase = 0; cmdBits = 0; sIdx = 1; sSub = 0;
        for (int d = 0; d < 8; d++) devIn[d] = (d < nDev);
        r = (nDev > 0);
      end
      2'd1: begin
        if (phase == 0) begin
          cmdShift = {b, cmdShift[7:1]};
          cmdBits++;
          if (cmdBits == 8) begin
            chk("R2", "search command byte", {56'd0, cmdShift}, 64'hF0);
            phase = 1;
          end
        end else begin
          if (sSub != 2) begin
            checks++; fails++;
            $display("FAIL R3 write out of order at index %0d: actual sub %0d expected 2", sIdx, sSub);
          end
          for (int d = 0; d < nDev; d++)
            if (devIn[d] && devRom[d][sIdx-1] != b) devIn[d] = 0;
          sIdx++; sSub = 0;
        end
      end
      default: begin
        if (phase != 1 || sSub == 2) begin
          checks++; fails++;
          $display("FAIL R3 read out of order at index %0d: actual sub %0d expected below 2", sIdx, sSub);
        end
        if (!(vanishAt != 0 && sIdx >= vanishAt))
          for (int d = 0; d < nDev; d++)
            if (devIn[d]) r = r & (sSub == 0 ? devRom[d][sIdx-1] : ~devRom[d][sIdx-1]);
        sSub++;
      end
    endcase
  endtask

  // Timeslot engine model: two idle cycles, then a done pulse
  initial begin
    forever begin
      @(negedge clk);
      slotDone = 1'b0;
      if (slotReq) begin
        logic [1:0] op = slotOp;
        logic       b = slotBit;
        logic       r;
        repeat (2) @(negedge clk);
        serve(op, b, r);
        slotRsp = r;
        slotDone = 1'b1;
      end
    end
  end

  // Monitor: pop and compare on each completion
  initial begin
    forever begin
      @(negedge clk);
      if (doneStrobe && rstN) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 unexpected completion: actual 1 expected 0");
        end else begin
          expT e = expQ.pop_front();
          chk(e.tag, "found", {63'd0, found}, {63'd0, e.fnd});
          chk(e.tag, "romId", romId, e.rom);
          chk({e.tag, " R8"}, "lastDevice", {63'd0, lastDevice}, {63'd0, e.last});
          chk({e.tag, " R6"}, "familyDisc", {60'd0, familyDisc}, {60'd0, e.fam});
        end
      end
    end
  end

  task automatic forgetExp();
    expK = 0; expLast = 0; expFam = 0;
  endtask

  // Driver: push the expected result, run one pass, wait for completion
  task automatic runSearch(bit expectFound, string tag, bit noisy);
    expT e;
    e.tag = tag;
    if (expectFound) begin
      int d = order[expK];
      int f = famFor(d);
      if (f > 0) expFam = f;
      e.fnd = 1; e.rom = devRom[d]; e.last = (expK == nDev - 1); e.fam = 4'(expFam);
      expLast = e.last;
      expK = expLast ? 0 : expK + 1;
    end else begin
      e.fnd = 0; e.rom = '0; e.last = 0; e.fam = '0;
      forgetExp();
    end
    expQ.push_back(e);
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    if (noisy) begin
      repeat (300) @(negedge clk);
      clearReq = 1'b1; startReq = 1'b1;
      @(negedge clk);
      clearReq = 1'b0; startReq = 1'b0;
    end
    while (!doneStrobe) @(negedge clk);
    @(negedge clk);
    chk("R11", "doneStrobe after pulse", {63'd0, doneStrobe}, 64'd0);
  endtask

  task automatic clearIdle();
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
    @(negedge clk);
    forgetExp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "found after reset", {63'd0, found}, 64'd0);
    chk("R11", "romId after reset", romId, 64'd0);
    chk("R11", "busy after reset", {62'd0, busy, slotReq}, 64'd0);
    chk("R11", "lastDevice after reset", {62'd0, lastDevice, doneStrobe}, 64'd0);

    // R1: empty bus
    nDev = 0;
    runSearch(0, "R1 empty bus", 0);

    // R4/R5/R7: three devices, two sharing a family code
    nDev = 3;
    devRom[0] = mkRom(8'h28, 48'h0000_0000_00A5);
    devRom[1] = mkRom(8'h28, 48'h0000_0000_005A);
    devRom[2] = mkRom(8'h10, 48'h1234_5678_9ABC);
    sortDevices();
    runSearch(1, "R4/R5/R7 first", 0);
    runSearch(1, "R4/R5/R7 second", 0);
    runSearch(1, "R4/R5/R7 third", 0);
    runSearch(0, "R1 after last device", 0);
    runSearch(1, "R1 restart first", 0);

    // R10: clear when idle
    clearIdle();
    chk("R10", "romId after clear", romId, 64'd0);
    chk("R10", "lastDevice/familyDisc after clear", {59'd0, lastDevice, familyDisc}, 64'd0);
    runSearch(1, "R10 first after clear", 0);
    runSearch(1, "R10 ignored while busy", 1);
    runSearch(1, "R10 third", 0);
    runSearch(0, "R1 wrap", 0);

    // R3: devices vanish mid-scan
    vanishAt = 5;
    runSearch(0, "R3 both ones", 0);
    vanishAt = 0;

    // R9: bad CRC
    nDev = 1;
    devRom[0] = mkRom(8'h3B, 48'hCAFE_0000_1111) ^ 64'h0100_0000_0000_0000;
    sortDevices();
    runSearch(0, "R9 bad crc", 0);
    devRom[0] = mkRom(8'h3B, 48'hCAFE_0000_1111);
    runSearch(1, "R9 good crc single", 0);
    clearIdle();

    // Four devices, deeper branching below the last discrepancy
    nDev = 4;
    devRom[0] = mkRom(8'h01, 48'h0000_0000_0001);
    devRom[1] = mkRom(8'h01, 48'h0000_0000_0003);
    devRom[2] = mkRom(8'h03, 48'h0000_0000_0001);
    devRom[3] = mkRom(8'h01, 48'h8000_0000_0001);
    sortDevices();
    for (int k = 0; k < 4; k++) runSearch(1, "R5/R7 four devices", 0);
    runSearch(0, "R1 four devices end", 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule